// File: doc/BRIEF.md
# Prescaler Divider with Event Flag

This block is a free-running binary up-counter driven by the system clock. Each time the full counter wraps from all-ones back to zero, it produces a periodic event. The event sets a sticky flag. The flag is then combined separately with two enable bits. One combination forms an interrupt request and the other forms a request to leave a low-power hold state. Both requests are registered.

Software-side logic can issue a strobe that clears the flag. A second strobe zeroes only the upper bits of the counter, which moves the next overflow later while the low bits keep counting in step. The block also exports two single-cycle tick pulses for a watchdog or other timers. One fires each time the low tap bits wrap and the other each time the full counter wraps.

Top module: `prescale_divider`

## Requirements
- R1: The counter advances by one on every clock. `tick_div_lo` is high for exactly one cycle after each clock edge at which the low `TAP_LO` bits wrap to zero, which is every 2^TAP_LO edges counted from reset release (edge 1024, 2048, ... by default).
- R2: At the edge where the full counter wraps from all-ones to zero (edge 16384 after reset release by default), `event_flag` becomes 1. `tick_div_hi` is high for exactly the following cycle.
- R3: `irq_req` is high in the cycle after an edge at which `event_flag` and `irq_en` were both 1, and low otherwise.
- R4: `hold_release` is high in the cycle after an edge at which `event_flag` and `hold_en` were both 1, and low otherwise.
- R5: A `part_clr` pulse forces the upper `CLR_BITS` counter bits (13..10 by default) to zero. The low bits still advance by one, so `tick_div_lo` keeps its phase and the next overflow is delayed accordingly.
- R6: A `flag_clr` pulse without a coincident overflow clears `event_flag` at that edge. The request outputs fall one edge later.
- R7: While the synchronous active-high `rst` is asserted at an edge, the counter, the flag, both requests and both ticks are cleared.
- R8: If an overflow and a `flag_clr` pulse occur at the same edge, the flag ends up set.
- R9: A `part_clr` pulse at the edge where the counter is all-ones produces no overflow event. `event_flag` does not set and `tick_div_hi` does not pulse, but `tick_div_lo` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, counted on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Lets the flag raise the interrupt request |
| hold_en | input | 1 | Lets the flag raise the hold-release request |
| flag_clr | input | 1 | One-cycle strobe that clears the event flag |
| part_clr | input | 1 | One-cycle strobe that zeroes the upper counter bits |
| event_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Registered interrupt request |
| hold_release | output | 1 | Registered hold-release request |
| tick_div_lo | output | 1 | One-cycle pulse when the low tap bits wrap |
| tick_div_hi | output | 1 | One-cycle pulse when the full counter wraps |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, a 4-bit partial clear and a tap at bit 10. The real overflow period of 16384 clocks is therefore exercised, including the interplay between an upper-bit clear and the low tap. Several overflow runs fit inside the cycle limit. Each scenario starts from reset, so the bench can predict every tick and flag edge from the count of clock edges alone. The exact cycle of a clear pulse, including the all-ones cycle, is within reach.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  typedef struct packed {
    logic irq;
    logic hold;
  } pdiv_req_t;
endpackage

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
  parameter int CNT_W    = 14,
  parameter int CLR_BITS = 4,
  parameter int TAP_LO   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic part_clr,
  output logic ovf_evt,
  output logic tick_lo,
  output logic tick_hi
);
  localparam int KEEP_W = CNT_W - CLR_BITS;

  logic [CNT_W-1:0]  cnt;
  logic [KEEP_W-1:0] keep_nxt;
  logic              wrap_all;
  logic              wrap_low;

  assign wrap_all = &cnt;
  assign wrap_low = &cnt[TAP_LO-1:0];
  assign keep_nxt = cnt[KEEP_W-1:0] + 1'b1;
  assign ovf_evt  = wrap_all & ~part_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tick_lo <= 1'b0;
      tick_hi <= 1'b0;
    end else begin
      if (part_clr) cnt <= {{CLR_BITS{1'b0}}, keep_nxt};
      else          cnt <= cnt + 1'b1;
      tick_lo <= wrap_low;
      tick_hi <= ovf_evt;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    !part_clr |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    part_clr |=> cnt[CNT_W-1:KEEP_W] == '0);

  assert_low_continue_R5: assert property (@(posedge clk) disable iff (rst)
    part_clr |=> cnt[KEEP_W-1:0] == KEEP_W'($past(cnt[KEEP_W-1:0]) + 1'b1));

  assert_hi_tick_after_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    tick_hi |-> cnt == '0);

  assert_no_hi_tick_on_clear_R9: assert property (@(posedge clk) disable iff (rst)
    part_clr |=> !tick_hi);
endmodule

// File: rtl/pdiv_flag.sv
module pdiv_flag
  import pdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_evt,
  input  logic      clr_evt,
  input  logic      irq_en,
  input  logic      hold_en,
  output logic      flag,
  output pdiv_req_t req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      req.irq  <= 1'b0;
      req.hold <= 1'b0;
    end else begin
      if (set_evt)      flag <= 1'b1;
      else if (clr_evt) flag <= 1'b0;
      req.irq  <= flag & irq_en;
      req.hold <= flag & hold_en;
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !set_evt) |=> !flag);

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (flag && irq_en) |=> req.irq);

  assert_irq_only_R3: assert property (@(posedge clk) disable iff (rst)
    !(flag && irq_en) |=> !req.irq);

  assert_hold_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && hold_en) |=> req.hold);

  assert_hold_only_R4: assert property (@(posedge clk) disable iff (rst)
    !(flag && hold_en) |=> !req.hold);
endmodule

// File: rtl/prescale_divider.sv
module prescale_divider
  import pdiv_pkg::*;
#(
  parameter int CNT_W    = 14,
  parameter int CLR_BITS = 4,
  parameter int TAP_LO   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic hold_en,
  input  logic flag_clr,
  input  logic part_clr,
  output logic event_flag,
  output logic irq_req,
  output logic hold_release,
  output logic tick_div_lo,
  output logic tick_div_hi
);
  logic      ovf_evt;
  pdiv_req_t req;

  pdiv_counter #(
    .CNT_W   (CNT_W),
    .CLR_BITS(CLR_BITS),
    .TAP_LO  (TAP_LO)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .part_clr(part_clr),
    .ovf_evt (ovf_evt),
    .tick_lo (tick_div_lo),
    .tick_hi (tick_div_hi)
  );

  pdiv_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_evt(ovf_evt),
    .clr_evt(flag_clr),
    .irq_en (irq_en),
    .hold_en(hold_en),
    .flag   (event_flag),
    .req    (req)
  );

  assign irq_req      = req.irq;
  assign hold_release = req.hold;

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> !event_flag && !irq_req && !hold_release && !tick_div_lo && !tick_div_hi);

  assert_flag_with_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick_div_hi |-> event_flag);
endmodule

// File: tb/tb_prescale_divider.sv
module tb_prescale_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_en = 1'b0, hold_en = 1'b0, flag_clr = 1'b0, part_clr = 1'b0;
  logic event_flag, irq_req, hold_release, tick_div_lo, tick_div_hi;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescale_divider dut (
    .clk(clk), .rst(rst), .irq_en(irq_en), .hold_en(hold_en),
    .flag_clr(flag_clr), .part_clr(part_clr), .event_flag(event_flag),
    .irq_req(irq_req), .hold_release(hold_release),
    .tick_div_lo(tick_div_lo), .tick_div_hi(tick_div_hi)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, edges, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      edges++;
    end
    @(negedge clk);
  endtask

  task automatic go_to(input int target);
    step(target - edges);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_en = 1'b0; hold_en = 1'b0; flag_clr = 1'b0; part_clr = 1'b0;
    step(3);
    rst = 1'b0;
    edges = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    step(2);
    check(event_flag, 1'b0, "R7", "flag in reset");
    check(irq_req, 1'b0, "R7", "irq in reset");
    check(hold_release, 1'b0, "R7", "hold in reset");
    check(tick_div_lo, 1'b0, "R7", "lo tick in reset");
    check(tick_div_hi, 1'b0, "R7", "hi tick in reset");
  endtask

  task automatic t_overflow_irq();
    do_reset();
    irq_en = 1'b1;
    go_to(1023);
    check(tick_div_lo, 1'b0, "R1", "lo tick before 1024");
    go_to(1024);
    check(tick_div_lo, 1'b1, "R1", "lo tick at 1024");
    go_to(1025);
    check(tick_div_lo, 1'b0, "R1", "lo tick width");
    go_to(2048);
    check(tick_div_lo, 1'b1, "R1", "lo tick at 2048");
    go_to(16383);
    check(event_flag, 1'b0, "R2", "flag before wrap");
    check(tick_div_hi, 1'b0, "R2", "hi tick before wrap");
    go_to(16384);
    check(event_flag, 1'b1, "R2", "flag on wrap");
    check(tick_div_hi, 1'b1, "R2", "hi tick on wrap");
    check(irq_req, 1'b0, "R3", "irq not yet");
    go_to(16385);
    check(irq_req, 1'b1, "R3", "irq one edge later");
    check(hold_release, 1'b0, "R4", "hold gated off");
    check(tick_div_hi, 1'b0, "R2", "hi tick width");
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check(event_flag, 1'b0, "R6", "flag cleared");
    check(irq_req, 1'b1, "R6", "irq still high one edge");
    step(1);
    check(irq_req, 1'b0, "R6", "irq falls after clear");
  endtask

  task automatic t_hold_path();
    do_reset();
    hold_en = 1'b1;
    go_to(16385);
    check(hold_release, 1'b1, "R4", "hold after flag");
    check(irq_req, 1'b0, "R3", "irq gated off");
    irq_en = 1'b1;
    step(1);
    check(irq_req, 1'b1, "R3", "irq after late enable");
    hold_en = 1'b0;
    step(1);
    check(hold_release, 1'b0, "R4", "hold after disable");
  endtask

  task automatic t_set_wins();
    do_reset();
    go_to(16383);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check(event_flag, 1'b1, "R8", "set beats clear");
  endtask

  task automatic t_part_clear();
    do_reset();
    go_to(16000);
    part_clr = 1'b1;
    step(1);
    part_clr = 1'b0;
    go_to(16384);
    check(event_flag, 1'b0, "R5", "no wrap at old point");
    check(tick_div_lo, 1'b1, "R5", "lo tick keeps phase");
    go_to(31743);
    check(event_flag, 1'b0, "R5", "flag before shifted wrap");
    go_to(31744);
    check(event_flag, 1'b1, "R5", "flag at shifted wrap");
    check(tick_div_hi, 1'b1, "R5", "hi tick at shifted wrap");
  endtask

  task automatic t_clear_at_ones();
    do_reset();
    go_to(16383);
    part_clr = 1'b1;
    step(1);
    part_clr = 1'b0;
    check(event_flag, 1'b0, "R9", "no flag when cleared at all-ones");
    check(tick_div_hi, 1'b0, "R9", "no hi tick when cleared at all-ones");
    check(tick_div_lo, 1'b1, "R9", "lo tick still fires");
    go_to(17408);
    check(tick_div_lo, 1'b1, "R9", "lo tick continues");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_overflow_irq();
        t_hold_path();
        t_set_wins();
        t_part_clear();
        t_clear_at_ones();
      end
      begin
        while (cycles < WATCHDOG) begin
          @(posedge clk);
          cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule